// File: doc/BRIEF.md
# Enable-Gated Parallel Port

This block is an 8-bit bidirectional parallel port whose activity hangs on one port-enable bit from a master configuration register. When the port is enabled, each pin set as an output is driven from an output-data register. Each pin is sampled into an input register, and a rising edge on a selected input bit raises an interrupt-pending flag. Any input bit can instead be given a ones catcher, which latches a 1 until software clears it. A minimal handshake flag drives a READY/WAIT indication after the output-data register is written, and holds it until the acknowledge input goes low.

Clearing the enable puts the port in a safe state. All pins float. The interrupt-pending flag cannot be newly set, but a flag that is already pending stays pending. The ones catchers become transparent and READY/WAIT stays low. Software sets direction, catcher selection and interrupt mask in this state, then sets the enable. A separate handshake enable keeps the handshake flag idle while it is clear, and it forces the internal acknowledge high.

Top module: `pio_gate_port`

## Requirements
- R1: After reset the outputs are as follows: `pad_oe_o` is 0, `pad_o` is 0, `ip_o` is 0, `rw_o` is 0 and `din_o` is 0. All direction bits reset to 1 (input).
- R2: A direction bit of 1 means input and 0 means output. `pad_oe_o` equals the inverted direction register while `port_en_i` is 1 and is all zero while it is 0. `pad_o` carries the output-data bits where `pad_oe_o` is 1 and 0 elsewhere.
- R3: While `port_en_i` is 0, no pin edge can set `ip_o`. A flag that is already set stays set until `ip_clr_i`.
- R4: While `port_en_i` is 1, a rising edge on `pad_i` sets `ip_o` two clock edges after the pin changes, but only when that bit's mask bit is 1 and its direction bit is 1. Edges on unmasked bits and on output bits have no effect.
- R5: A pulse on `ip_clr_i` clears `ip_o` at the next clock edge when no new event occurs at that edge.
- R6: While `port_en_i` is 1, an input bit whose catcher-select bit is 1 latches a 1 from the pin into `din_o` and keeps it after the pin falls. Writing the catcher-clear register clears the bits written as 0 and leaves the bits written as 1 unchanged.
- R7: A `din_o` bit is transparent while `port_en_i` is 0 or while its catcher-select bit is 0. Transparent means it follows `pad_i` two clock edges later.
- R8: When `hs_en_i` and `port_en_i` are both 1, a write to the output-data register raises `rw_o` after that edge. `rw_o` then stays high until the effective acknowledge is sampled low.
- R9: `rw_o` is 0 whenever `port_en_i` is 0. An output-data write made while the port is disabled does not raise it.
- R10: `ack_eff_o` equals `ack_i` while `hs_en_i` is 1 and is forced to 1 while `hs_en_i` is 0. While `hs_en_i` is 0 the handshake flag is held idle.
- R11: Register writes are decoded from `cfg_sel_i` as follows: 0 is direction, 1 is catcher select, 2 is output data, 3 is interrupt mask and 4 is catcher clear. Writes to codes 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_en_i | input | 1 | Port enable from the master configuration register |
| hs_en_i | input | 1 | Handshake enable |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 3 | Register select |
| cfg_wdata_i | input | 8 | Register write data |
| ip_clr_i | input | 1 | Clears the interrupt-pending flag |
| ack_i | input | 1 | Acknowledge pin |
| pad_i | input | 8 | Pin input levels |
| pad_o | output | 8 | Pin output levels |
| pad_oe_o | output | 8 | Pin output enables |
| din_o | output | 8 | Input register (catchers or transparent) |
| ip_o | output | 1 | Interrupt-pending flag |
| rw_o | output | 1 | READY/WAIT indication |
| ack_eff_o | output | 1 | Effective internal acknowledge |

## Verification
The properties assume that `port_en_i`, `hs_en_i`, `ip_clr_i` and the register-write inputs change only between clock edges. They also assume that the pins are already in the clock domain, because the block samples `pad_i` through a single register. The bench drives every input on the falling edge. It holds each pin pattern for at least two edges before judging catcher or interrupt results, so every rising edge it creates is seen once. Random direction, data and enable values are mixed with writes to the unused select codes, which stay in the legal encoding range.

// File: rtl/pio_pkg.sv
package pio_pkg;
  typedef enum logic [2:0] {
    SEL_DIR   = 3'd0,
    SEL_CATCH = 3'd1,
    SEL_DOUT  = 3'd2,
    SEL_IMASK = 3'd3,
    SEL_CCLR  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/pio_cfg_regs.sv
module pio_cfg_regs
  import pio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [2:0]   sel_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] csel_o,
  output logic [W-1:0] dout_o,
  output logic [W-1:0] imask_o,
  output logic         cclr_stb_o,
  output logic         dout_wr_o
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o   <= '1;
      csel_o  <= '0;
      dout_o  <= '0;
      imask_o <= '0;
    end else if (we_i) begin
      case (sel)
        SEL_DIR:   dir_o   <= wdata_i;
        SEL_CATCH: csel_o  <= wdata_i;
        SEL_DOUT:  dout_o  <= wdata_i;
        SEL_IMASK: imask_o <= wdata_i;
        default: ;
      endcase
    end
  end

  assign cclr_stb_o = we_i && (sel == SEL_CCLR);
  assign dout_wr_o  = we_i && (sel == SEL_DOUT);
endmodule

// File: rtl/pio_in_stage.sv
module pio_in_stage #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         port_en_i,
  input  logic [W-1:0] pad_i,
  input  logic [W-1:0] csel_i,
  input  logic         cclr_stb_i,
  input  logic [W-1:0] cclr_keep_i,
  output logic [W-1:0] pin_s_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] din_o
);
  logic [W-1:0] pin_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_s_o <= '0;
      pin_p   <= '0;
    end else begin
      pin_s_o <= pad_i;
      pin_p   <= pin_s_o;
    end
  end

  assign rise_o = pin_s_o & ~pin_p;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic transp;
    logic keep;
    assign transp = !port_en_i || !csel_i[b];
    assign keep   = !cclr_stb_i || cclr_keep_i[b];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     din_o[b] <= 1'b0;
      else if (transp) din_o[b] <= pin_s_o[b];
      else             din_o[b] <= (din_o[b] && keep) || pin_s_o[b];
    end
  end
endmodule

// File: rtl/pio_irq.sv
module pio_irq #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         port_en_i,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] imask_i,
  input  logic [W-1:0] dir_i,
  input  logic         clr_i,
  output logic         ip_o
);
  logic evt;
  assign evt = |(rise_i & imask_i & dir_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ip_o <= 1'b0;
    else if (port_en_i && evt)  ip_o <= 1'b1;
    else if (clr_i)             ip_o <= 1'b0;
  end
endmodule

// File: rtl/pio_hs.sv
module pio_hs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic port_en_i,
  input  logic hs_en_i,
  input  logic dout_wr_i,
  input  logic ack_i,
  output logic ack_eff_o,
  output logic rw_o
);
  logic busy;
  assign ack_eff_o = hs_en_i ? ack_i : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     busy <= 1'b0;
    else if (!hs_en_i)               busy <= 1'b0;
    else if (dout_wr_i && port_en_i) busy <= 1'b1;
    else if (!ack_eff_o)             busy <= 1'b0;
  end

  assign rw_o = busy && port_en_i;
endmodule

// File: rtl/pio_gate_port.sv
module pio_gate_port #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         port_en_i,
  input  logic         hs_en_i,
  input  logic         cfg_we_i,
  input  logic [2:0]   cfg_sel_i,
  input  logic [W-1:0] cfg_wdata_i,
  input  logic         ip_clr_i,
  input  logic         ack_i,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] pad_o,
  output logic [W-1:0] pad_oe_o,
  output logic [W-1:0] din_o,
  output logic         ip_o,
  output logic         rw_o,
  output logic         ack_eff_o
);
  logic [W-1:0] dir_q, csel_q, dout_q, imask_q;
  logic [W-1:0] pin_s, rise;
  logic         cclr_stb, dout_wr;

  pio_cfg_regs #(.W(W)) i_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .dir_o(dir_q), .csel_o(csel_q), .dout_o(dout_q), .imask_o(imask_q),
    .cclr_stb_o(cclr_stb), .dout_wr_o(dout_wr)
  );

  pio_in_stage #(.W(W)) i_in (
    .clk_i, .rst_ni, .port_en_i, .pad_i,
    .csel_i(csel_q), .cclr_stb_i(cclr_stb), .cclr_keep_i(cfg_wdata_i),
    .pin_s_o(pin_s), .rise_o(rise), .din_o
  );

  pio_irq #(.W(W)) i_irq (
    .clk_i, .rst_ni, .port_en_i,
    .rise_i(rise), .imask_i(imask_q), .dir_i(dir_q),
    .clr_i(ip_clr_i), .ip_o
  );

  pio_hs i_hs (
    .clk_i, .rst_ni, .port_en_i, .hs_en_i,
    .dout_wr_i(dout_wr), .ack_i, .ack_eff_o, .rw_o
  );

  assign pad_oe_o = port_en_i ? ~dir_q : '0;
  assign pad_o    = dout_q & pad_oe_o;
endmodule

// File: rtl/pio_gate_chk.sv
module pio_gate_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         port_en_i,
  input logic         hs_en_i,
  input logic         ip_clr_i,
  input logic         ip_o,
  input logic         rw_o,
  input logic         ack_i,
  input logic         ack_eff_o,
  input logic [W-1:0] pad_oe_o,
  input logic [W-1:0] din_o,
  input logic [W-1:0] pin_s
);
  p_no_new_ip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!port_en_i && !ip_o) |=> !ip_o);

  p_ip_kept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ip_o && !ip_clr_i) |=> ip_o);

  p_pins_float_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en_i |-> (pad_oe_o == '0));

  p_transparent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en_i |=> (din_o == $past(pin_s)));

  p_no_wait_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en_i |-> !rw_o);

  p_ack_forced_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_en_i ? (ack_eff_o == ack_i) : ack_eff_o);
endmodule

bind pio_gate_port pio_gate_chk #(.W(W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .port_en_i(port_en_i), .hs_en_i(hs_en_i),
  .ip_clr_i(ip_clr_i), .ip_o(ip_o), .rw_o(rw_o), .ack_i(ack_i),
  .ack_eff_o(ack_eff_o), .pad_oe_o(pad_oe_o), .din_o(din_o), .pin_s(pin_s)
);

// File: tb/test_pio_gate_port.sv
module test_pio_gate_port;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0, hs_en = 1'b0, we = 1'b0, ip_clr = 1'b0, ack = 1'b1;
  logic [2:0]   sel = '0;
  logic [W-1:0] wdata = '0, pad = '0;
  logic [W-1:0] pad_o, pad_oe, din;
  logic         ip, rw, ack_eff;
  int           total = 0, bad = 0;
  logic [W-1:0] m_dir = '1, m_dout = '0;

  always #10 clk = ~clk;

  pio_gate_port #(.W(W)) i_pio_gate_port (
    .clk_i(clk), .rst_ni(rst_n), .port_en_i(en), .hs_en_i(hs_en),
    .cfg_we_i(we), .cfg_sel_i(sel), .cfg_wdata_i(wdata), .ip_clr_i(ip_clr),
    .ack_i(ack), .pad_i(pad), .pad_o(pad_o), .pad_oe_o(pad_oe), .din_o(din),
    .ip_o(ip), .rw_o(rw), .ack_eff_o(ack_eff)
  );

  function automatic logic [W-1:0] exp_oe(logic e, logic [W-1:0] d);
    return e ? ~d : '0;
  endfunction
  function automatic logic [W-1:0] exp_pad(logic e, logic [W-1:0] d, logic [W-1:0] o);
    return o & exp_oe(e, d);
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] s, logic [W-1:0] d);
    sel = s; wdata = d; we = 1'b1;
    tick(1);
    we = 1'b0;
    if (s == 3'd0) m_dir = d;
    if (s == 3'd2) m_dout = d;
  endtask

  task automatic pulse_clr();
    ip_clr = 1'b1; tick(1); ip_clr = 1'b0;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk);
    // R1 reset state
    chk("R1 oe", pad_oe, '0); chk("R1 pad", pad_o, '0);
    chk("R1 ip", {7'd0, ip}, '0); chk("R1 rw", {7'd0, rw}, '0);
    chk("R1 din", din, '0);
    rst_n = 1'b1;
    tick(1);

    // R2 directed
    wr(3'd0, 8'hF0); wr(3'd2, 8'hA5); en = 1'b1; tick(1);
    chk("R2 oe", pad_oe, 8'h0F); chk("R2 pad", pad_o, 8'h05);

    // R2/R11 random
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] d, o;
      d = W'($urandom); o = W'($urandom);
      en = 1'($urandom);
      wr(3'd0, d); wr(3'd2, o);
      wr(3'(5 + ($urandom % 3)), W'($urandom));
      chk("R2 oe rand", pad_oe, exp_oe(en, m_dir));
      chk("R11 pad rand", pad_o, exp_pad(en, m_dir, m_dout));
    end

    // interrupt
    en = 1'b1; wr(3'd0, 8'hFF); wr(3'd3, 8'h01); pad = '0; tick(3); pulse_clr();
    chk("R5 ip clear", {7'd0, ip}, '0);
    pad = 8'h02; tick(2);
    chk("R4 unmasked edge", {7'd0, ip}, '0);
    pad = 8'h03; tick(1);
    chk("R4 one edge early", {7'd0, ip}, '0);
    tick(1);
    chk("R4 masked edge", {7'd0, ip}, 8'h01);
    pulse_clr();
    chk("R5 clr", {7'd0, ip}, '0);
    en = 1'b0; pad = '0; tick(2); pad = 8'h01; tick(3);
    chk("R3 no set disabled", {7'd0, ip}, '0);
    en = 1'b1; pad = '0; tick(2); pad = 8'h01; tick(2);
    chk("R4 set again", {7'd0, ip}, 8'h01);
    en = 1'b0; tick(3);
    chk("R3 kept disabled", {7'd0, ip}, 8'h01);
    chk("R2 float", pad_oe, '0);
    en = 1'b1; pulse_clr();
    wr(3'd0, 8'hFE); pad = '0; tick(2); pad = 8'h01; tick(3);
    chk("R4 output bit", {7'd0, ip}, '0);
    wr(3'd0, 8'hFF); wr(3'd3, 8'h00);

    // catchers
    wr(3'd1, 8'h0F); pad = '0; tick(2); wr(3'd4, 8'h00); tick(1);
    chk("R6 cleared", din, 8'h00);
    pad = 8'h11; tick(2);
    chk("R6 catch", din, 8'h11);
    pad = 8'h00; tick(2);
    chk("R6 hold", din, 8'h01);
    pad = 8'h02; tick(2); pad = 8'h00; tick(2);
    chk("R6 two", din, 8'h03);
    wr(3'd4, 8'hFD); tick(1);
    chk("R6 partial clear", din, 8'h01);
    wr(3'd4, 8'hFE); tick(1);
    chk("R6 clear", din, 8'h00);
    en = 1'b0; pad = 8'h01; tick(2);
    chk("R7 transp high", din, 8'h01);
    pad = 8'h00; tick(2);
    chk("R7 transp low", din, 8'h00);
    en = 1'b1; wr(3'd1, 8'h00); pad = 8'h40; tick(2); pad = 8'h00; tick(2);
    chk("R7 unselected", din, 8'h00);

    // handshake
    hs_en = 1'b1; ack = 1'b1; en = 1'b1; tick(1);
    chk("R10 ack pass", {7'd0, ack_eff}, 8'h01);
    wr(3'd2, 8'h3C);
    chk("R8 rw set", {7'd0, rw}, 8'h01);
    tick(2);
    chk("R8 rw holds", {7'd0, rw}, 8'h01);
    ack = 1'b0; tick(1);
    chk("R10 ack low", {7'd0, ack_eff}, '0);
    chk("R8 rw cleared", {7'd0, rw}, '0);
    ack = 1'b1;
    en = 1'b0; wr(3'd2, 8'h11); en = 1'b1; tick(0);
    chk("R9 disabled write", {7'd0, rw}, '0);
    wr(3'd2, 8'h22); en = 1'b0; tick(0);
    chk("R9 rw blocked", {7'd0, rw}, '0);
    en = 1'b1; hs_en = 1'b0; ack = 1'b0; tick(0);
    chk("R10 forced high", {7'd0, ack_eff}, 8'h01);
    tick(1);
    chk("R10 idle", {7'd0, rw}, '0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule